// File: doc/BRIEF.md
# Indirect Effective Address Generator

This block produces the 16-bit effective address for an 8-bit processor core that has the extended indirect addressing forms. On a one-cycle start pulse it samples a mode code, an 8-bit operand, a 16-bit operand and the two index registers. Indexed zero-page forms are computed directly. Indirect forms fetch a two-byte pointer through a byte-wide read port and return that pointer as the address. Each operation ends with a one-cycle done strobe.

Pointers are stored low byte first. The high byte sits at the next address. For the zero-page indirect form, that next address wraps within page zero. The read port returns data one cycle after the request. A pointer fetch therefore takes two back-to-back requests and finishes four cycles after start. The direct forms finish one cycle after start. An unknown mode code finishes in the same cycle as a direct form and flags an error.

Top module: `ind_ea_gen`

## Requirements
- R1: After reset, done, err and rd_en are low and ea is zero.
- R2: Mode code 0 (zero-page, X) returns ea = {8'h00, (op8 + idx_x) mod 256}. done rises in the cycle after start, and no read is issued.
- R3: Mode code 1 (zero-page, Y) returns ea = {8'h00, (op8 + idx_y) mod 256}, with the same timing as R2 and no read.
- R4: Mode code 2 (zero-page indirect) reads address {8'h00, op8} and then {8'h00, (op8+1) mod 256}. It returns ea = {second byte, first byte}, and the high byte of rd_addr is always zero.
- R5: Mode code 3 (absolute indirect) reads op16 and then (op16+1) mod 65536. It returns ea = {second byte, first byte}.
- R6: Mode code 4 (absolute X indirect) forms the pointer location p = (op16 + idx_x) mod 65536, carrying into the high byte. It reads p and then (p+1) mod 65536, and returns ea = {second byte, first byte}.
- R7: In a pointer mode, rd_en is high for exactly the two cycles after the start edge. Read data is taken one cycle after each request, and done rises four cycles after start, with rd_en low while done is high.
- R8: Mode codes 5, 6 and 7 raise done and err together in the cycle after start, issue no read and return ea = 0. err is never high without done.
- R9: done is a single-cycle pulse for each accepted start.
- R10: While a pointer fetch is in progress, start and all operand inputs are ignored. The result uses the values sampled at the accepted start, and no extra done follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation (accepted only when idle) |
| mode | input | 3 | Addressing mode code (0..4 valid) |
| op8 | input | 8 | Zero-page operand byte |
| op16 | input | 16 | Absolute operand |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 8 | Read data, valid one cycle after rd_en |
| done | output | 1 | Result valid strobe |
| err | output | 1 | Unsupported mode, valid with done |
| ea | output | 16 | Effective address |

## Verification
The bench aims at the wrap points:
- A zero-page index sum that passes 0xFF must stay in page zero. A design that carries into the high byte returns an address in page one.
- A zero-page pointer at 0xFF must take its high byte from 0x0000. A 16-bit increment would read 0x0100 instead.
- An absolute-plus-X sum must carry into the high byte. An 8-bit sum would point to the wrong page.
- A pointer at 0xFFFF must wrap to 0x0000 for its second byte.

Further tests cover the timing and control rules. The read-latency timing check catches swapped byte order and data taken a cycle early. A burst of new start and operand values during a fetch catches a design that restarts or mixes operands mid-fetch. The unknown codes must give an error with no read.

// File: rtl/ind_ea_gen.sv
module ind_ea_gen #(
  parameter int DW = 8,
  parameter int MW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MW-1:0]   mode,
  input  logic [DW-1:0]   op8,
  input  logic [2*DW-1:0] op16,
  input  logic [DW-1:0]   idx_x,
  input  logic [DW-1:0]   idx_y,
  output logic            rd_en,
  output logic [2*DW-1:0] rd_addr,
  input  logic [DW-1:0]   rd_data,
  output logic            done,
  output logic            err,
  output logic [2*DW-1:0] ea
);
  localparam int AW = 2 * DW;
  localparam logic [MW-1:0] M_ZPX  = MW'(0);
  localparam logic [MW-1:0] M_ZPY  = MW'(1);
  localparam logic [MW-1:0] M_ZPI  = MW'(2);
  localparam logic [MW-1:0] M_ABI  = MW'(3);
  localparam logic [MW-1:0] M_ABXI = MW'(4);

  typedef enum logic [1:0] {S_IDLE, S_RLO, S_RHI, S_FIN} st_t;
  st_t st;

  logic [AW-1:0] ptr_q;
  logic          zp_q;
  logic [DW-1:0] lo_q;

  wire           is_dir = (mode == M_ZPX) || (mode == M_ZPY);
  wire           is_ptr = (mode == M_ZPI) || (mode == M_ABI) || (mode == M_ABXI);
  wire [DW-1:0]  zsum   = op8 + ((mode == M_ZPY) ? idx_y : idx_x);

  logic [AW-1:0] ptr_d;
  always_comb begin
    case (mode)
      M_ZPI:   ptr_d = {{DW{1'b0}}, op8};
      M_ABXI:  ptr_d = op16 + {{DW{1'b0}}, idx_x};
      default: ptr_d = op16;
    endcase
  end

  wire [DW-1:0] zp_next = ptr_q[DW-1:0] + 1'b1;
  wire [AW-1:0] hi_addr = zp_q ? {{DW{1'b0}}, zp_next} : ptr_q + 1'b1;

  assign rd_en   = (st == S_RLO) || (st == S_RHI);
  assign rd_addr = (st == S_RHI) ? hi_addr : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ptr_q <= '0;
      zp_q  <= 1'b0;
      lo_q  <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
      ea    <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (is_dir) begin
            ea   <= {{DW{1'b0}}, zsum};
            done <= 1'b1;
          end else if (is_ptr) begin
            ptr_q <= ptr_d;
            zp_q  <= (mode == M_ZPI);
            st    <= S_RLO;
          end else begin
            ea   <= '0;
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        S_RLO: st <= S_RHI;
        S_RHI: begin
          lo_q <= rd_data;
          st   <= S_FIN;
        end
        default: begin
          ea   <= {rd_data, lo_q};
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  assert_err_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_no_read_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_en);

  assert_read_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |=> rd_en);

  assert_read_pair_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (st == S_RHI)) |=> !rd_en);

  assert_fin_gives_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIN) |=> done);

  assert_zp_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && zp_q) |-> (rd_addr[AW-1:DW] == '0));

  assert_busy_holds_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(ptr_q));
endmodule

// File: tb/ind_ea_gen_tb.sv
`timescale 1ns/1ps
module ind_ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [7:0]  op8 = '0;
  logic [15:0] op16 = '0;
  logic [7:0]  idx_x = '0;
  logic [7:0]  idx_y = '0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        done;
  logic        err;
  logic [15:0] ea;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ind_ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op8(op8),
    .op16(op16), .idx_x(idx_x), .idx_y(idx_y), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .err(err), .ea(ea)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd13;
    return t ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mem_byte(rd_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [2:0] m, input logic [7:0] o8,
                        input logic [15:0] o16, input logic [7:0] x, input logic [7:0] y,
                        input logic [15:0] exp_ea, input logic exp_err, input int exp_lat,
                        input int exp_n, input logic [15:0] a0, input logic [15:0] a1,
                        input bit disturb);
    int lat;
    int n;
    logic [15:0] got0;
    logic [15:0] got1;
    got0 = '0; got1 = '0;
    @(negedge clk);
    start = 1'b1; mode = m; op8 = o8; op16 = o16; idx_x = x; idx_y = y;
    @(negedge clk);
    start = 1'b0; lat = 1; n = 0;
    if (disturb) begin
      start = 1'b1; mode = 3'd1; op8 = ~o8; op16 = ~o16; idx_x = ~x; idx_y = ~y;
    end
    while (!done && lat < 8) begin
      if (rd_en) begin
        if (n == 0) got0 = rd_addr;
        if (n == 1) got1 = rd_addr;
        n++;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    chk(done == 1'b1, {tag, " done seen"}, 32'(done), 32'd1);
    chk(lat == exp_lat, {tag, " R7 latency"}, 32'(lat), 32'(exp_lat));
    chk(err == exp_err, {tag, " err"}, 32'(err), 32'(exp_err));
    chk(ea == exp_ea, {tag, " ea"}, 32'(ea), 32'(exp_ea));
    chk(n == exp_n, {tag, " read count"}, 32'(n), 32'(exp_n));
    if (exp_n == 2) begin
      chk(got0 == a0, {tag, " low ptr addr"}, 32'(got0), 32'(a0));
      chk(got1 == a1, {tag, " high ptr addr"}, 32'(got1), 32'(a1));
    end
    @(negedge clk);
    chk(done == 1'b0, {tag, " R9 single pulse"}, 32'(done), 32'd0);
    if (disturb) begin
      for (int i = 0; i < 4; i++) begin
        chk(done == 1'b0 && rd_en == 1'b0, {tag, " R10 no extra op"}, 32'({done, rd_en}), 32'd0);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset;
    chk(done == 1'b0, "R1 done", 32'(done), 32'd0);
    chk(err == 1'b0, "R1 err", 32'(err), 32'd0);
    chk(rd_en == 1'b0, "R1 rd_en", 32'(rd_en), 32'd0);
    chk(ea == 16'h0, "R1 ea", 32'(ea), 32'd0);
  endtask

  task automatic t_zp_index;
    run_op("R2 zpx", 3'd0, 8'h10, 16'hBEEF, 8'h05, 8'h77, 16'h0015, 1'b0, 1, 0, 0, 0, 0);
    run_op("R2 zpx wrap", 3'd0, 8'hF0, 16'h1234, 8'h20, 8'h00, 16'h0010, 1'b0, 1, 0, 0, 0, 0);
    run_op("R3 zpy", 3'd1, 8'h40, 16'h0000, 8'h99, 8'h0C, 16'h004C, 1'b0, 1, 0, 0, 0, 0);
    run_op("R3 zpy wrap", 3'd1, 8'hFF, 16'hFFFF, 8'h00, 8'h02, 16'h0001, 1'b0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_zp_ind;
    run_op("R4 zpi", 3'd2, 8'h34, 16'h5555, 8'h11, 8'h22,
           {mem_byte(16'h0035), mem_byte(16'h0034)}, 1'b0, 4, 2, 16'h0034, 16'h0035, 0);
    run_op("R4 zpi page wrap", 3'd2, 8'hFF, 16'h0000, 8'h00, 8'h00,
           {mem_byte(16'h0000), mem_byte(16'h00FF)}, 1'b0, 4, 2, 16'h00FF, 16'h0000, 0);
  endtask

  task automatic t_abs_ind;
    run_op("R5 absi", 3'd3, 8'h00, 16'h2A7C, 8'h40, 8'h00,
           {mem_byte(16'h2A7D), mem_byte(16'h2A7C)}, 1'b0, 4, 2, 16'h2A7C, 16'h2A7D, 0);
    run_op("R5 absi page cross", 3'd3, 8'h00, 16'h30FF, 8'h00, 8'h00,
           {mem_byte(16'h3100), mem_byte(16'h30FF)}, 1'b0, 4, 2, 16'h30FF, 16'h3100, 0);
    run_op("R5 absi top wrap", 3'd3, 8'h00, 16'hFFFF, 8'h00, 8'h00,
           {mem_byte(16'h0000), mem_byte(16'hFFFF)}, 1'b0, 4, 2, 16'hFFFF, 16'h0000, 0);
  endtask

  task automatic t_absx_ind;
    run_op("R6 absxi", 3'd4, 8'h00, 16'h1200, 8'h06, 8'h00,
           {mem_byte(16'h1207), mem_byte(16'h1206)}, 1'b0, 4, 2, 16'h1206, 16'h1207, 0);
    run_op("R6 absxi carry", 3'd4, 8'h00, 16'h12F0, 8'h20, 8'hAA,
           {mem_byte(16'h1311), mem_byte(16'h1310)}, 1'b0, 4, 2, 16'h1310, 16'h1311, 0);
  endtask

  task automatic t_bad;
    for (int m = 5; m < 8; m++)
      run_op("R8 bad mode", 3'(m), 8'h12, 16'h3456, 8'h01, 8'h02, 16'h0000, 1'b1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_busy;
    run_op("R10 busy", 3'd4, 8'h00, 16'h4410, 8'h03, 8'h00,
           {mem_byte(16'h4414), mem_byte(16'h4413)}, 1'b0, 4, 2, 16'h4413, 16'h4414, 1);
    run_op("R10 after busy", 3'd0, 8'h01, 16'h0000, 8'h01, 8'h00, 16'h0002, 1'b0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zp_index();
    t_zp_ind();
    t_abs_ind();
    t_absx_ind();
    t_bad();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule